// File: doc/BRIEF.md
# Transmit-Only Identification Byte Streamer

This block sends the contents of a 128-byte identification memory out over a serial data line. It needs no host command and no addressing. Its only timing input is a one-way clock from the receiving side. Each rising edge of that clock moves the stream by one bit. Every byte takes a slot of nine clocks: eight data bits, most significant first, and then a filler bit driven high.

After reset the line stays released for a silent lead-in of nine clocks. Streaming then starts at address 0, steps up one address per slot, and wraps from the last address back to 0.

The block runs in a system clock domain. It brings the external clock in through a two-flop synchronizer and acts on each detected rising edge. Its outputs are a data bit and an output-enable, which together drive an open-drain pin. The byte itself is fetched through a synchronous read port with one cycle of latency into a storage array outside the block. A restart input sends the stream back to address 0 with no lead-in. An enable input pauses the stream.

Top module: `ddc_stream_tx`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `sda_oe` is 0 and `rd_addr` is 0.
- R2: After reset, the first nine detected rising edges of `vclk` leave `sda_oe` at 0.
- R3: The tenth rising edge after reset sets `sda_oe` to 1 and drives `sda_out` with bit 7 of the byte at address 0.
- R4: Within a slot, edges one to eight drive the byte's bits in order from bit 7 down to bit 0.
- R5: The ninth edge of every slot drives `sda_out` to 1 with `sda_oe` at 1.
- R6: `rd_addr` holds the address of the byte being sent and steps up by exactly one on the edge that sends bit 0. `rd_data` must return the byte at `rd_addr` one `clk` cycle later.
- R7: After address 127 (7Fh) the next slot sends address 0.
- R8: A one-cycle `restart` sets `rd_addr` to 0 and `sda_oe` to 0 on the next `clk` edge. The very next rising `vclk` edge drives bit 7 of address 0, with no lead-in.
- R9: While `enable` is 0, `sda_oe` is 0 from the next `clk` edge on, and `vclk` edges neither move `rd_addr` nor move the bit position. Once `enable` returns to 1, the stream resumes from where it stopped.
- R10: If `vclk` is first seen high at `clk` edge k, the outputs change at edge k+2 and are unchanged after edges k and k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Stream gate; 0 releases the line and freezes position |
| restart | input | 1 | Resume from address 0 on the next edge, no lead-in |
| vclk | input | 1 | Asynchronous one-way stream clock |
| rd_addr | output | 7 | Read address into the byte array |
| rd_data | input | 8 | Byte returned one cycle after `rd_addr` |
| sda_out | output | 1 | Data bit for the open-drain pin |
| sda_oe | output | 1 | Drive enable for the open-drain pin |

## Verification
Every result is counted from the `clk` edge that first sees `vclk` high. The synchronizer takes two edges to pass the edge through, so the output and address registers change on the third edge. One directed pulse samples the outputs at the falling edge after each of those three rising edges, to show nothing moves early. Every other pulse holds `vclk` high and then low for four cycles each before it is sampled, so every register has settled when it is read. `restart` and `enable` each act on the first `clk` edge after they change, and their results are read two cycles later.

// File: rtl/ddc_stream_tx.sv
module ddc_stream_tx #(
  parameter int ADDR_W     = 7,
  parameter int DATA_W     = 8,
  parameter int LEAD_EDGES = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              restart,
  input  logic              vclk,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              sda_out,
  output logic              sda_oe
);
  localparam int SLOT   = DATA_W + 1;
  localparam int IDX_W  = $clog2(SLOT);
  localparam int LEAD_W = $clog2(LEAD_EDGES + 1);
  localparam logic [IDX_W-1:0]  LAST_BIT = IDX_W'(DATA_W - 1);
  localparam logic [IDX_W-1:0]  FILL_IDX = IDX_W'(DATA_W);
  localparam logic [LEAD_W-1:0] LEAD_MAX = LEAD_W'(LEAD_EDGES);

  logic              vs1, vs2, vs3;
  logic              rise;
  logic [LEAD_W-1:0] lead_cnt;
  logic              lead_done;
  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] shifted;
  logic              sda_q, oe_q;

  assign rise      = vs2 & ~vs3;
  assign lead_done = (lead_cnt == LEAD_MAX);
  assign shifted   = rd_data << idx;
  assign rd_addr   = addr;
  assign sda_out   = sda_q;
  assign sda_oe    = oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vs1 <= 1'b0;
      vs2 <= 1'b0;
      vs3 <= 1'b0;
    end else begin
      vs1 <= vclk;
      vs2 <= vs1;
      vs3 <= vs2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lead_cnt <= '0;
      idx      <= '0;
      addr     <= '0;
      sda_q    <= 1'b1;
      oe_q     <= 1'b0;
    end else if (restart) begin
      lead_cnt <= LEAD_MAX;
      idx      <= '0;
      addr     <= '0;
      sda_q    <= 1'b1;
      oe_q     <= 1'b0;
    end else if (!enable) begin
      oe_q <= 1'b0;
    end else if (rise) begin
      if (!lead_done) begin
        lead_cnt <= lead_cnt + 1'b1;
      end else begin
        oe_q  <= 1'b1;
        sda_q <= (idx == FILL_IDX) ? 1'b1 : shifted[DATA_W-1];
        if (idx == LAST_BIT) addr <= addr + 1'b1;
        idx <= (idx == FILL_IDX) ? '0 : idx + 1'b1;
      end
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (!sda_oe && rd_addr == '0));

  assert_lead_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !lead_done |-> !sda_oe);

  assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr != $past(rd_addr)) |-> (rd_addr == ADDR_W'($past(rd_addr) + 1'b1) || rd_addr == '0));

  assert_restart_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (rd_addr == '0 && !sda_oe));

  assert_pause_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !restart) |=> ($stable(rd_addr) && !sda_oe));

  assert_oe_after_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(rise));
endmodule

// File: tb/ddc_stream_tx_bench.sv
module ddc_stream_tx_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b1;
  logic       restart = 1'b0;
  logic       vclk = 1'b0;
  logic [6:0] rd_addr;
  logic [7:0] rd_data;
  logic       sda_out, sda_oe;

  int checks = 0;
  int fails  = 0;
  int m_lead, m_idx, m_addr;
  string next_tag;

  always #10 clk = ~clk;

  ddc_stream_tx u_ddc_stream_tx (
    .clk(clk), .rst_n(rst_n), .enable(en), .restart(restart), .vclk(vclk),
    .rd_addr(rd_addr), .rd_data(rd_data), .sda_out(sda_out), .sda_oe(sda_oe)
  );

  function automatic logic [7:0] mem_byte(input int a);
    return 8'((a * 73 + 29) ^ (a >> 2));
  endfunction

  always_ff @(posedge clk) rd_data <= mem_byte(int'(rd_addr));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse(input bit timed);
    logic e_oe, e_sda, p_oe, p_sda;
    logic [7:0] b;
    string tag, atag;
    e_sda = 1'b1;
    atag = "R6";
    if (!en) begin
      e_oe = 1'b0; tag = "R9"; atag = "R9";
    end else if (m_lead > 0) begin
      m_lead--; e_oe = 1'b0; tag = "R2";
    end else begin
      e_oe = 1'b1;
      b = mem_byte(m_addr);
      tag = (m_idx == 8) ? "R5" : "R4";
      if (next_tag != "") begin tag = next_tag; next_tag = ""; end
      e_sda = (m_idx == 8) ? 1'b1 : b[7 - m_idx];
      if (m_idx == 7) begin
        if (m_addr == 127) atag = "R7";
        m_addr = (m_addr + 1) % 128;
      end
      m_idx = (m_idx == 8) ? 0 : m_idx + 1;
    end
    p_oe = sda_oe; p_sda = sda_out;
    @(negedge clk) vclk = 1'b1;
    if (timed) begin
      @(negedge clk);
      chk("R10 oe after 1 edge", int'(sda_oe), int'(p_oe));
      @(negedge clk);
      chk("R10 oe after 2 edges", int'(sda_oe), int'(p_oe));
      chk("R10 sda after 2 edges", int'(sda_out), int'(p_sda));
      @(negedge clk);
      chk("R10 oe after 3 edges", int'(sda_oe), int'(e_oe));
      repeat (1) @(negedge clk);
    end else begin
      repeat (4) @(negedge clk);
    end
    vclk = 1'b0;
    repeat (4) @(negedge clk);
    chk({tag, " oe"}, int'(sda_oe), int'(e_oe));
    if (e_oe) chk({tag, " sda"}, int'(sda_out), int'(e_sda));
    chk({atag, " addr"}, int'(rd_addr), m_addr);
  endtask

  task automatic do_restart();
    @(negedge clk) restart = 1'b1;
    @(negedge clk) restart = 1'b0;
    @(negedge clk);
    chk("R8 oe cleared", int'(sda_oe), 0);
    chk("R8 addr cleared", int'(rd_addr), 0);
    m_lead = 0; m_idx = 0; m_addr = 0; next_tag = "R8";
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 oe in reset", int'(sda_oe), 0);
    chk("R1 addr in reset", int'(rd_addr), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 oe after reset", int'(sda_oe), 0);
    m_lead = 9; m_idx = 0; m_addr = 0; next_tag = "R3";
  endtask

  // {enable, restart, pulse count}
  localparam logic [17:0] STEPS [0:4] = '{
    {1'b1, 1'b0, 16'd30},
    {1'b0, 1'b0, 16'd4},
    {1'b1, 1'b0, 16'd25},
    {1'b1, 1'b1, 16'd20},
    {1'b1, 1'b0, 16'd1200}
  };

  initial begin
    int total;
    total = 0;
    do_reset();
    for (int s = 0; s < 5; s++) begin
      if (STEPS[s][16]) do_restart();
      en = STEPS[s][17];
      repeat (2) @(negedge clk);
      if (!en) chk("R9 oe released", int'(sda_oe), 0);
      for (int p = 0; p < int'(STEPS[s][15:0]); p++) begin
        total++;
        pulse(total == 10);
      end
    end
    // restart in the middle of the lead-in
    do_reset();
    for (int p = 0; p < 3; p++) pulse(1'b0);
    do_restart();
    for (int p = 0; p < 10; p++) pulse(1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule